// File: doc/BRIEF.md
# Serial Port Control, Status and Interrupt Registers

This block is the software-visible register file of a two-wire serial port. It holds a control word, a status word and a serial interrupt flag, and it sits between a simple 32-bit register bus and the protocol engine that runs the wire. Whenever the engine reports a new 5-bit state code, the block stores the code in the status word and raises the flag. When software has interrupts enabled, it also asserts an interrupt request.

The status code is frozen while the flag is set, so software always reads the code that caused the interrupt. A code that arrives while the flag is still set is not lost. The block parks it, and when software clears the flag, the flag drops for one cycle. It then rises again with the parked code. When the port is disabled, the flag reads zero, codes from the engine are ignored and any parked code is dropped.

The flag is kept by a four-state machine:
- `ST_IDLE`: the flag is clear. A code strobe moves it to `ST_FLAG`.
- `ST_FLAG`: the flag is set and nothing is parked.
  - A strobe moves it to `ST_HELD`.
  - A clear moves it to `ST_IDLE`.
  - A clear together with a strobe moves it to `ST_RELOAD`.
- `ST_HELD`: the flag is set and a code is parked.
  - A further strobe replaces the parked code.
  - A clear moves it to `ST_RELOAD`.
- `ST_RELOAD`: the flag is clear for one cycle, and the block then returns to `ST_FLAG` with the parked code. A strobe in this cycle takes precedence over the parked code.

Any state returns to `ST_IDLE` when the port enable reads 0.

Top module: `sio_csr_top`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, the status word reads 0x0000_00F8 (the reset code 0x1F in bits [7:3]), and `irq` is low.
- R2: The control word sits at offset 0x0 and keeps three writable bits: interrupt enable at bit 7, port enable at bit 6 and acknowledge enable at bit 2. Each reads back as written and drives its output pin from the cycle after the write.
- R3: Control bits 31:8, 5, 4, 1 and 0 ignore writes and read 0. The status word at offset 0x4 reads 0 in bits 31:8 and in bits 2:0. Any other offset reads 0, and `bus_rdata` is 0 while `bus_sel` is low.
- R4: While the port is enabled and the flag is clear, an engine strobe sets the flag (control bit 3 and `sflag`) and places the code in status bits [7:3] on the next cycle.
- R5: `irq` is high exactly when the visible flag is set and interrupt enable is 1.
- R6: While the flag is set, the status word does not change. Bus writes to the status offset have no effect.
- R7: A strobe that arrives while the flag is set is parked, and a later strobe replaces it. On a clear, the flag reads 0 for one cycle and then reads 1 with the parked code in the status word.
- R8: Writing 1 to control bit 3 clears the flag on the next cycle. Writing 0 to it leaves the flag unchanged, and a clear with nothing parked leaves the flag at 0.
- R9: While port enable is 0, the flag reads 0, strobes are ignored and any parked code is dropped. The status word keeps the last latched code.
- R10: A clear and a strobe in the same cycle produce one cycle with the flag at 0, after which the flag is set with the code from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_stb | input | 1 | New state code from the engine |
| eng_code | input | CODE_W | State code value |
| port_en | output | 1 | Port enable control bit |
| int_en | output | 1 | Interrupt enable control bit |
| ack_en | output | 1 | Acknowledge enable control bit |
| sflag | output | 1 | Visible serial interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 4-bit offset, 5-bit codes and a reset code of 0x1F. With these values every code value, including the all-ones reset code, fits the status field. They also put the offsets 0x0 and 0x4 and the unmapped offsets within reach of the directed reads. The stimulus walks the flag machine through every state and every transition. This includes a clear and a strobe in the same cycle, a parked code replaced by a newer one, and disabling the port while a code is parked.

// File: rtl/sio_csr_pkg.sv
`timescale 1ns/1ps
package sio_csr_pkg;

    localparam int REG_W    = 32;
    localparam int BIT_ACK  = 2;
    localparam int BIT_FLAG = 3;
    localparam int BIT_EN   = 6;
    localparam int BIT_IE   = 7;
    localparam int CODE_LSB = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLAG,
        ST_HELD,
        ST_RELOAD
    } flag_state_e;

endpackage

// File: rtl/sio_csr_ctrl.sv
`timescale 1ns/1ps
module sio_csr_ctrl
    import sio_csr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFF = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic              en_o,
    output logic              ie_o,
    output logic              ack_o,
    output logic              clr_o
);

    logic wr_hit;
    logic unused_wbits;

    assign wr_hit = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));
    assign clr_o  = wr_hit && bus_wdata[BIT_FLAG];

    assign unused_wbits = ^{bus_wdata[REG_W-1:BIT_IE+1], bus_wdata[BIT_EN-1:BIT_FLAG+1],
                            bus_wdata[BIT_ACK-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            ie_o  <= 1'b0;
            ack_o <= 1'b0;
        end else if (wr_hit) begin
            en_o  <= bus_wdata[BIT_EN];
            ie_o  <= bus_wdata[BIT_IE];
            ack_o <= bus_wdata[BIT_ACK];
        end
    end

    // R2: a control write lands in the stored bits one cycle later
    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (en_o == $past(bus_wdata[BIT_EN]) && ie_o == $past(bus_wdata[BIT_IE])
                    && ack_o == $past(bus_wdata[BIT_ACK])));

    // R2: without a write the stored bits hold
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(en_o) && $stable(ie_o) && $stable(ack_o)));

endmodule

// File: rtl/sio_csr_flag_fsm.sv
`timescale 1ns/1ps
module sio_csr_flag_fsm
    import sio_csr_pkg::*;
#(
    parameter int                CODE_W   = 5,
    parameter logic [CODE_W-1:0] RST_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              flag_o,
    output logic [CODE_W-1:0] code_o
);

    flag_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] pend_q, pend_d;
    logic              flag_raw;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // code and parked-code registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RST_CODE;
            pend_q <= '0;
        end else begin
            code_q <= code_d;
            pend_q <= pend_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        pend_d  = pend_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (stb_i) begin
                        state_d = ST_FLAG;
                        code_d  = code_i;
                    end
                end
                ST_FLAG: begin
                    if (stb_i) pend_d = code_i;
                    if (clr_i && stb_i) state_d = ST_RELOAD;
                    else if (clr_i)     state_d = ST_IDLE;
                    else if (stb_i)     state_d = ST_HELD;
                end
                ST_HELD: begin
                    if (stb_i) pend_d = code_i;
                    if (clr_i) state_d = ST_RELOAD;
                end
                ST_RELOAD: begin
                    state_d = ST_FLAG;
                    code_d  = stb_i ? code_i : pend_q;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FLAG, ST_HELD: flag_raw = 1'b1;
            default:          flag_raw = 1'b0;
        endcase
    end

    assign flag_o = flag_raw && en_i;
    assign code_o = code_q;

    // R4: a strobe with the flag clear latches its code and raises the flag
    p_latch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en_i && stb_i) |=> (flag_raw && code_q == $past(code_i)));

    // R6: the status code cannot move out of a flagged cycle
    p_code_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_raw && en_i) |=> (code_q == $past(code_q)));

    // R7: the reload cycle always lands back in a flagged state
    p_reload_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOAD && en_i) |=> (state_q == ST_FLAG));

    // R8: a clear always drops the flag for at least the next cycle
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_raw && en_i && clr_i) |=> !flag_raw);

    // R9: a disabled port forgets its flag and any parked code
    p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == ST_IDLE));

    // R10: clear with a simultaneous strobe goes through the reload cycle
    p_clear_and_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAG && en_i && clr_i && stb_i) |=> (state_q == ST_RELOAD));

endmodule

// File: rtl/sio_csr_rdmux.sv
`timescale 1ns/1ps
module sio_csr_rdmux
    import sio_csr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CODE_W   = 5,
    parameter int CTRL_OFF = 0,
    parameter int STAT_OFF = 4
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_i,
    input  logic              ie_i,
    input  logic              ack_i,
    input  logic              flag_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [REG_W-1:0]  rdata_o
);

    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic [REG_W-1:0] ctrl_word;
    logic [REG_W-1:0] stat_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_IE]   = ie_i;
        ctrl_word[BIT_EN]   = en_i;
        ctrl_word[BIT_FLAG] = flag_i;
        ctrl_word[BIT_ACK]  = ack_i;
    end

    always_comb begin
        stat_word                    = '0;
        stat_word[CODE_MSB:CODE_LSB] = code_i;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            if (addr_i == ADDR_W'(CTRL_OFF))      rdata_o = ctrl_word;
            else if (addr_i == ADDR_W'(STAT_OFF)) rdata_o = stat_word;
        end
    end

endmodule

// File: rtl/sio_csr_top.sv
`timescale 1ns/1ps
module sio_csr_top
    import sio_csr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                CODE_W   = 5,
    parameter logic [CODE_W-1:0] RST_CODE = 5'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_stb,
    input  logic [CODE_W-1:0] eng_code,
    output logic              port_en,
    output logic              int_en,
    output logic              ack_en,
    output logic              sflag,
    output logic              irq
);

    localparam int CTRL_OFF = 0;
    localparam int STAT_OFF = 4;

    logic              clr_pulse;
    logic [CODE_W-1:0] code_cur;

    sio_csr_ctrl #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFF (CTRL_OFF)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .en_o      (port_en),
        .ie_o      (int_en),
        .ack_o     (ack_en),
        .clr_o     (clr_pulse)
    );

    sio_csr_flag_fsm #(
        .CODE_W   (CODE_W),
        .RST_CODE (RST_CODE)
    ) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (port_en),
        .clr_i  (clr_pulse),
        .stb_i  (eng_stb),
        .code_i (eng_code),
        .flag_o (sflag),
        .code_o (code_cur)
    );

    sio_csr_rdmux #(
        .ADDR_W   (ADDR_W),
        .CODE_W   (CODE_W),
        .CTRL_OFF (CTRL_OFF),
        .STAT_OFF (STAT_OFF)
    ) rdmux_i (
        .sel_i   (bus_sel),
        .addr_i  (bus_addr),
        .en_i    (port_en),
        .ie_i    (int_en),
        .ack_i   (ack_en),
        .flag_i  (sflag),
        .code_i  (code_cur),
        .rdata_o (bus_rdata)
    );

    assign irq = sflag && int_en;

    // R9: with the port disabled a strobe never shows up as a flag
    p_no_flag_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !sflag);

endmodule

// File: tb/sio_csr_top_tb_top.sv
`timescale 1ns/1ps
module sio_csr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_stb = 1'b0;
    logic [4:0]  eng_code = '0;
    logic        port_en, int_en, ack_en, sflag, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #2.5 clk = ~clk;

    sio_csr_top dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .eng_stb (eng_stb), .eng_code (eng_code),
        .port_en (port_en), .int_en (int_en), .ack_en (ack_en),
        .sflag (sflag), .irq (irq)
    );

    // behavioural reference model
    int m_en = 0, m_ie = 0, m_ack = 0;
    int m_flag = 0, m_parked = 0, m_reload = 0;
    int m_code = 31, m_pend = 0;
    int w_hit, w_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_ack = 0;
            m_flag = 0; m_parked = 0; m_reload = 0;
            m_code = 31; m_pend = 0;
        end else begin
            w_hit = (bus_sel && bus_wr && bus_addr == 4'h0) ? 1 : 0;
            w_clr = (w_hit != 0 && bus_wdata[3]) ? 1 : 0;
            if (m_en == 0) begin
                m_flag = 0; m_parked = 0; m_reload = 0;
            end else if (m_reload != 0) begin
                m_reload = 0;
                m_flag = 1;
                m_code = eng_stb ? int'(eng_code) : m_pend;
            end else if (m_flag != 0) begin
                if (eng_stb) begin m_pend = int'(eng_code); m_parked = 1; end
                if (w_clr != 0) begin
                    m_flag = 0;
                    if (m_parked != 0) begin m_reload = 1; m_parked = 0; end
                end
            end else if (eng_stb) begin
                m_flag = 1;
                m_code = int'(eng_code);
            end
            if (w_hit != 0) begin
                m_ie = int'(bus_wdata[7]); m_en = int'(bus_wdata[6]); m_ack = int'(bus_wdata[2]);
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v;
        v = '0;
        if (bus_sel && bus_addr == 4'h0) begin
            v[7] = (m_ie != 0); v[6] = (m_en != 0);
            v[3] = (m_flag != 0 && m_en != 0); v[2] = (m_ack != 0);
        end else if (bus_sel && bus_addr == 4'h4) begin
            v[7:3] = 5'(m_code);
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 sflag vs model", {31'b0, sflag}, {31'b0, (m_flag != 0 && m_en != 0)});
            chk("R5 irq vs model", {31'b0, irq}, {31'b0, (m_flag != 0 && m_en != 0 && m_ie != 0)});
            chk("R2 port_en vs model", {31'b0, port_en}, {31'b0, (m_en != 0)});
            chk("R2 int_en vs model", {31'b0, int_en}, {31'b0, (m_ie != 0)});
            chk("R2 ack_en vs model", {31'b0, ack_en}, {31'b0, (m_ack != 0)});
            chk("R3 rdata vs model", bus_rdata, exp_rdata());
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc_cnt);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic strobe(input logic [4:0] c);
        eng_stb = 1'b1; eng_code = c;
        tick();
        eng_stb = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        rd_chk("R1 ctrl after reset", 4'h0, 32'h0000_0000);
        rd_chk("R1 status after reset", 4'h4, 32'h0000_00F8);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        strobe(5'h05);
        chk("R9 strobe ignored disabled", {31'b0, sflag}, 32'h0);
        rd_chk("R9 status unchanged disabled", 4'h4, 32'h0000_00F8);

        wr_reg(4'h0, 32'h0000_00C4);
        rd_chk("R2 ctrl readback", 4'h0, 32'h0000_00C4);
        wr_reg(4'h0, 32'hFFFF_FFF7);
        rd_chk("R3 reserved ctrl bits", 4'h0, 32'h0000_00C4);
        rd_chk("R3 unmapped offset", 4'h8, 32'h0);

        strobe(5'h0A);
        chk("R4 flag raised", {31'b0, sflag}, 32'h1);
        rd_chk("R4 status code", 4'h4, 32'h0000_0050);
        chk("R5 irq raised", {31'b0, irq}, 32'h1);

        strobe(5'h11);
        rd_chk("R6 status frozen", 4'h4, 32'h0000_0050);
        strobe(5'h12);
        wr_reg(4'h4, 32'h0000_0000);
        rd_chk("R6 status write ignored", 4'h4, 32'h0000_0050);
        chk("R7 flag held", {31'b0, sflag}, 32'h1);

        wr_reg(4'h0, 32'h0000_00C4);
        chk("R8 write zero keeps flag", {31'b0, sflag}, 32'h1);

        wr_reg(4'h0, 32'h0000_00CC);
        chk("R7 reload cycle flag low", {31'b0, sflag}, 32'h0);
        tick();
        chk("R7 parked code flags", {31'b0, sflag}, 32'h1);
        rd_chk("R7 latest parked code", 4'h4, 32'h0000_0090);

        wr_reg(4'h0, 32'h0000_00CC);
        chk("R8 clear flag", {31'b0, sflag}, 32'h0);
        tick();
        chk("R8 stays clear", {31'b0, sflag}, 32'h0);

        wr_reg(4'h0, 32'h0000_0044);
        strobe(5'h03);
        chk("R5 flag without irq", {31'b0, sflag}, 32'h1);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);

        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0000_004C;
        eng_stb = 1'b1; eng_code = 5'h1E;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; eng_stb = 1'b0;
        chk("R10 flag low one cycle", {31'b0, sflag}, 32'h0);
        tick();
        chk("R10 flag set again", {31'b0, sflag}, 32'h1);
        rd_chk("R10 code of strobe", 4'h4, 32'h0000_00F0);

        wr_reg(4'h0, 32'h0000_0000);
        chk("R9 flag hidden disabled", {31'b0, sflag}, 32'h0);
        strobe(5'h02);
        wr_reg(4'h0, 32'h0000_0040);
        chk("R9 flag clear re-enabled", {31'b0, sflag}, 32'h0);
        rd_chk("R9 status kept", 4'h4, 32'h0000_00F0);

        strobe(5'h07);
        strobe(5'h08);
        wr_reg(4'h0, 32'h0000_0000);
        wr_reg(4'h0, 32'h0000_0040);
        tick();
        chk("R9 parked code dropped", {31'b0, sflag}, 32'h0);
        rd_chk("R9 status after drop", 4'h4, 32'h0000_0038);

        repeat (3) tick();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule